// File: doc/BRIEF.md
# Float-to-Signed-Integer Ceiling Converter

This unit takes one IEEE-754 binary floating-point value per transfer and returns the smallest integer that is not below it. The value can be half, single or double precision. The result is a signed two's-complement integer of 32 or 64 bits. The source format and the result size are chosen per transfer by two selectors. Narrow operands sit in the low bits of the 64-bit operand bus, and the bits above them are ignored.

Results that cannot be represented are clamped to the limit of the chosen width, and a status flag is raised. NaN inputs also raise that flag. A second flag marks results that lost a fraction. One selector code is not a format: it produces a zero result and a separate indication.

Data moves in and out on valid/ready streams through a single output register. An operand is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when its contents leave on the same edge. While `out_valid` is high and `out_ready` is low, the output register keeps its contents and `in_ready` is low. This is how back-pressure reaches the producer.

Top module: `fp_ceil_to_int`

## Requirements
- R1: `in_fmt` selects the operand format. 2'b00 is single precision in bits [31:0]. 2'b01 is double precision in bits [63:0]. 2'b11 is half precision in bits [15:0]. Operand bits above the selected width do not affect the result.
- R2: A positive value that is not an integer rounds up to the next integer. A negative value that is not an integer rounds toward zero. In both cases `out_inexact` is 1 and `out_invalid` is 0.
- R3: A finite value that is already an integer and fits the chosen width converts exactly, with both flags 0.
- R4: Values strictly between -1 and 0, and negative zero, give 0. Positive values strictly between 0 and 1, including subnormals, give 1. Both flags follow R2 and R3.
- R5: A NaN of any format gives result 0, with `out_invalid` 1 and `out_inexact` 0.
- R6: A value whose ceiling lies outside the signed range of the chosen width, and any infinity, is clamped to the largest or smallest value of that width. In this case `out_invalid` is 1 and `out_inexact` is 0, so the two flags are never both 1.
- R7: `in_wide` = 0 selects a 32-bit result, sign-extended across all 64 output bits. `in_wide` = 1 selects a 64-bit result. The value -2^31 is in range for the 32-bit size.
- R8: `in_fmt` = 2'b10 sets `out_undef` to 1, the result to 0 and both flags to 0. All other codes give `out_undef` 0.
- R9: An operand taken on an edge appears on the outputs, with `out_valid` high, after that same edge. Outputs stay unchanged while `out_valid` is high and `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R10: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_operand | input | 64 | Floating-point operand, right-aligned |
| in_fmt | input | 2 | Format code: 00 single, 01 double, 11 half, 10 illegal |
| in_wide | input | 1 | Result size: 0 = 32-bit, 1 = 64-bit |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Signed integer result (32-bit results are sign-extended) |
| out_invalid | output | 1 | NaN input, or result clamped |
| out_inexact | output | 1 | A nonzero fraction was discarded |
| out_undef | output | 1 | Illegal format code |

## Verification
Two conditions can meet in one conversion: a discarded fraction and range overflow. An example is 2^31 - 0.5 with a 32-bit result. Its ceiling is 2^31, one past the limit, and it also has a fractional part. The bench sends this value and the neighbour 2^31 - 1.5, which rounds up to exactly 2^31 - 1. It expects a clamped result with only the invalid flag for the first, and an in-range result with only the inexact flag for the second. Throughout the run, a repeating `out_ready` pattern stalls the output, so new operands meet a full register. The scoreboard then checks that no result is lost, duplicated or reordered.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int OP_W   = 64;            // operand bus and result width
  localparam int FRAC_W = 52;            // common left-aligned fraction width
  localparam int EXP_W  = 13;            // signed unbiased exponent width
  localparam int MAG_W  = OP_W + 2;      // magnitude after rounding, with headroom
  localparam int N_FMT  = 3;             // legal formats

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_BAD = 2'b10,
    FMT_HLF = 2'b11
  } fmt_e;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [FRAC_W-1:0]       frac;
    logic                    is_nan;
    logic                    is_inf;
    logic                    is_zero;
    logic                    is_sub;
  } unpacked_t;

  typedef struct packed {
    logic [OP_W-1:0] value;
    logic            invalid;
    logic            inexact;
    logic            undef;
  } conv_t;

  // lane 0 = half, 1 = single, 2 = double
  function automatic int lane_exp_w(input int lane);
    case (lane)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int lane_frac_w(input int lane);
    case (lane)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpc_field_split.sv
module fpc_field_split
  import fpc_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] raw,
  output unpacked_t      fields
);
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic          exp_ones;
  logic          exp_zero;
  logic          frac_any;

  assign exp_f    = raw[FW +: EW];
  assign frac_f   = raw[FW-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_any = |frac_f;

  always_comb begin
    fields.sign    = raw[EW+FW];
    fields.exp     = EXP_W'(int'(exp_f) - BIAS);
    fields.frac    = FRAC_W'(frac_f) << (FRAC_W - FW);
    fields.is_nan  = exp_ones & frac_any;
    fields.is_inf  = exp_ones & ~frac_any;
    fields.is_zero = exp_zero & ~frac_any;
    fields.is_sub  = exp_zero & frac_any;
  end
endmodule

// File: rtl/fpc_unpack.sv
module fpc_unpack
  import fpc_pkg::*;
(
  input  logic [OP_W-1:0] operand,
  input  logic [1:0]      fmt,
  output unpacked_t       fields
);
  unpacked_t lane_f [N_FMT];

  for (genvar gi = 0; gi < N_FMT; gi++) begin : g_lane
    localparam int EW = lane_exp_w(gi);
    localparam int FW = lane_frac_w(gi);
    fpc_field_split #(.EW(EW), .FW(FW)) u_split (
      .raw    (operand[EW+FW:0]),
      .fields (lane_f[gi])
    );
  end

  always_comb begin
    case (fmt_e'(fmt))
      FMT_HLF: fields = lane_f[0];
      FMT_SGL: fields = lane_f[1];
      FMT_DBL: fields = lane_f[2];
      default: fields = '0;
    endcase
  end
endmodule

// File: rtl/fpc_ceil_core.sv
module fpc_ceil_core
  import fpc_pkg::*;
(
  input  unpacked_t        fields,
  output logic [MAG_W-1:0] mag,
  output logic             frac_nz,
  output logic             huge
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int SH_W  = SIG_W + OP_W;
  localparam int SH_AW = $clog2(OP_W);
  localparam int INT_W = SH_W - FRAC_W;

  logic [SH_W-1:0]  shifted;
  logic [INT_W-1:0] int_part;
  logic [MAG_W-1:0] trunc;
  logic             bump;

  assign shifted  = SH_W'({1'b1, fields.frac}) << fields.exp[SH_AW-1:0];
  assign int_part = shifted[SH_W-1:FRAC_W];

  always_comb begin
    trunc   = '0;
    frac_nz = 1'b0;
    huge    = 1'b0;
    if (fields.is_nan || fields.is_inf || fields.is_zero) begin
      trunc = '0;
    end else if (fields.is_sub || fields.exp < 0) begin
      frac_nz = 1'b1;
    end else if (fields.exp > EXP_W'(OP_W - 1)) begin
      huge = 1'b1;
    end else begin
      trunc   = MAG_W'(int_part);
      frac_nz = |shifted[FRAC_W-1:0];
    end
    bump = frac_nz & ~fields.sign;
    mag  = trunc + MAG_W'(bump);
  end
endmodule

// File: rtl/fpc_saturate.sv
module fpc_saturate
  import fpc_pkg::*;
(
  input  logic             sign,
  input  logic [MAG_W-1:0] mag,
  input  logic             frac_nz,
  input  logic             huge,
  input  logic             is_nan,
  input  logic             is_inf,
  input  logic             wide,
  output conv_t            res
);
  localparam int HALF_W = OP_W / 2;

  localparam logic [MAG_W-1:0] POS_LIM_N = MAG_W'((65'd1 << (HALF_W - 1)) - 65'd1);
  localparam logic [MAG_W-1:0] NEG_LIM_N = MAG_W'(65'd1 << (HALF_W - 1));
  localparam logic [MAG_W-1:0] POS_LIM_W = MAG_W'((65'd1 << (OP_W - 1)) - 65'd1);
  localparam logic [MAG_W-1:0] NEG_LIM_W = MAG_W'(65'd1 << (OP_W - 1));

  logic [MAG_W-1:0] lim;
  logic             over;
  logic [OP_W-1:0]  signed_val;
  logic [OP_W-1:0]  max_val;
  logic [OP_W-1:0]  min_val;

  always_comb begin
    if (wide) lim = sign ? NEG_LIM_W : POS_LIM_W;
    else      lim = sign ? NEG_LIM_N : POS_LIM_N;
    over       = huge | is_inf | (mag > lim);
    signed_val = sign ? (~mag[OP_W-1:0] + OP_W'(1)) : mag[OP_W-1:0];
    max_val    = wide ? POS_LIM_W[OP_W-1:0] : POS_LIM_N[OP_W-1:0];
    min_val    = wide ? NEG_LIM_W[OP_W-1:0] : ~POS_LIM_N[OP_W-1:0];

    res = '0;
    if (is_nan) begin
      res.invalid = 1'b1;
    end else if (over) begin
      res.value   = sign ? min_val : max_val;
      res.invalid = 1'b1;
    end else begin
      res.value   = wide ? signed_val
                         : {{HALF_W{signed_val[HALF_W-1]}}, signed_val[HALF_W-1:0]};
      res.inexact = frac_nz;
    end
  end
endmodule

// File: rtl/fp_ceil_to_int.sv
module fp_ceil_to_int
  import fpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_operand,
  input  logic [1:0]      in_fmt,
  input  logic            in_wide,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_result,
  output logic            out_invalid,
  output logic            out_inexact,
  output logic            out_undef
);
  unpacked_t        fields;
  logic [MAG_W-1:0] mag;
  logic             frac_nz;
  logic             huge;
  conv_t            conv;
  conv_t            next_q;
  conv_t            hold_q;
  logic             vld_q;

  fpc_unpack u_unpack (
    .operand (in_operand),
    .fmt     (in_fmt),
    .fields  (fields)
  );

  fpc_ceil_core u_core (
    .fields  (fields),
    .mag     (mag),
    .frac_nz (frac_nz),
    .huge    (huge)
  );

  fpc_saturate u_sat (
    .sign    (fields.sign),
    .mag     (mag),
    .frac_nz (frac_nz),
    .huge    (huge),
    .is_nan  (fields.is_nan),
    .is_inf  (fields.is_inf),
    .wide    (in_wide),
    .res     (conv)
  );

  always_comb begin
    next_q = conv;
    if (fmt_e'(in_fmt) == FMT_BAD) begin
      next_q       = '0;
      next_q.undef = 1'b1;
    end
  end

  assign in_ready = ~vld_q | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) hold_q <= next_q;
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = hold_q.value;
  assign out_invalid = hold_q.invalid;
  assign out_inexact = hold_q.inexact;
  assign out_undef   = hold_q.undef;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_fmt,
  input logic        in_wide,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact,
  input logic        out_undef
);
  logic narrow_q;
  logic bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      bad_q    <= 1'b0;
    end else if (in_valid && in_ready) begin
      narrow_q <= ~in_wide;
      bad_q    <= (in_fmt == 2'b10);
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact)); // R6

  AST_UNDEF_TRACKS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_undef == bad_q)); // R8

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |-> (out_result == 64'd0 && !out_invalid && !out_inexact)); // R8

  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && narrow_q) |-> (out_result[63:32] == {32{out_result[31]}})); // R7

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_invalid)
                                   && $stable(out_inexact) && $stable(out_undef))); // R9

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R9

  always_comb begin
    if (!rst_n) AST_RESET_IDLE: assert (!out_valid); // R10
  end
endmodule

bind fp_ceil_to_int fpc_checker u_fpc_checker (.*);

// File: tb/test_fp_ceil_to_int.sv
module test_fp_ceil_to_int;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] value;
    logic        inv;
    logic        inx;
    logic        und;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_fmt = 2'b00;
  logic        in_wide = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_undef;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    stall_on = 1'b0;
  int    cyc = 0;
  exp_t  sb[$];

  fp_ceil_to_int i_fp_ceil_to_int (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic send(input logic [63:0] op, input logic [1:0] f, input logic w,
                      input logic [63:0] ev, input logic inv, input logic inx,
                      input logic und, input string tag);
    exp_t e;
    @(negedge clk);
    in_operand = op;
    in_fmt     = f;
    in_wide    = w;
    in_valid   = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    e.value = ev; e.inv = inv; e.inx = inx; e.und = und; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
    in_valid   = 1'b0;
    in_operand = {64{1'b1}};
  endtask

  // monitor: sets the ready pattern, then checks any transfer due at the next edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_on ? ((cyc % 4) != 1 && (cyc % 7) != 2) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        n_checks++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected result: actual %h expected none", out_result);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (out_result !== e.value || out_invalid !== e.inv ||
              out_inexact !== e.inx || out_undef !== e.und) begin
            n_fail++;
            $display("FAIL %s: actual %h inv=%b inx=%b und=%b expected %h inv=%b inx=%b und=%b",
                     e.tag, out_result, out_invalid, out_inexact, out_undef,
                     e.value, e.inv, e.inx, e.und);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 out_valid in reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;

    // R1 format selection, with junk above narrow operands
    send(64'hDEAD_BEEF_3FC0_0000, 2'b00, 1'b0, 64'd2, 0, 1, 0, "R1 single junk-high 1.5");
    send(64'hFFFF_FFFF_FFFF_4100, 2'b11, 1'b0, 64'd3, 0, 1, 0, "R1 half junk-high 2.5");
    send(64'h4008_0000_0000_0000, 2'b01, 1'b1, 64'd3, 0, 0, 0, "R3 double 3.0");
    // R2 ceiling direction
    send(64'h0000_0000_BFC0_0000, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, "R2 single -1.5");
    send(64'hC004_0000_0000_0000, 2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, 0, "R2 double -2.5");
    // R3 exact
    send(64'h0000_0000_0000_7BFF, 2'b11, 1'b1, 64'd65504, 0, 0, 0, "R3 half max 65504");
    // R4 around zero
    send(64'h0000_0000_BE80_0000, 2'b00, 1'b0, 64'd0, 0, 1, 0, "R4 single -0.25");
    send(64'h0000_0000_8000_0000, 2'b00, 1'b0, 64'd0, 0, 0, 0, "R4 single -0");
    send(64'h0000_0000_0000_0001, 2'b00, 1'b1, 64'd1, 0, 1, 0, "R4 single subnormal");
    send(64'h0000_0000_3F00_0000, 2'b00, 1'b0, 64'd1, 0, 1, 0, "R4 single 0.5");

    stall_on = 1'b1;
    // R5 NaN
    send(64'h0000_0000_7FC0_0000, 2'b00, 1'b0, 64'd0, 1, 0, 0, "R5 single NaN");
    send(64'h0000_0000_0000_7E00, 2'b11, 1'b1, 64'd0, 1, 0, 0, "R5 half NaN");
    // R6 saturation
    send(64'h0000_0000_7F80_0000, 2'b00, 1'b0, 64'h0000_0000_7FFF_FFFF, 1, 0, 0, "R6 single +inf n32");
    send(64'hFFF0_0000_0000_0000, 2'b01, 1'b1, 64'h8000_0000_0000_0000, 1, 0, 0, "R6 double -inf w64");
    send(64'h0000_0000_4F00_0000, 2'b00, 1'b0, 64'h0000_0000_7FFF_FFFF, 1, 0, 0, "R6 single 2^31 n32");
    send(64'h43E0_0000_0000_0000, 2'b01, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0, 0, "R6 double 2^63 w64");
    send(64'h41DF_FFFF_FFE0_0000, 2'b01, 1'b0, 64'h0000_0000_7FFF_FFFF, 1, 0, 0, "R6 double 2^31-0.5 n32");
    send(64'h41DF_FFFF_FFA0_0000, 2'b01, 1'b0, 64'h0000_0000_7FFF_FFFF, 0, 1, 0, "R2 double 2^31-1.5 n32");
    // R7 sizes and boundaries
    send(64'h0000_0000_4F00_0000, 2'b00, 1'b1, 64'h0000_0000_8000_0000, 0, 0, 0, "R7 single 2^31 w64");
    send(64'h0000_0000_CF00_0000, 2'b00, 1'b0, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, "R7 single -2^31 n32");
    send(64'hC3E0_0000_0000_0000, 2'b01, 1'b1, 64'h8000_0000_0000_0000, 0, 0, 0, "R7 double -2^63 w64");
    // R8 illegal format
    send(64'h0000_0000_3FC0_0000, 2'b10, 1'b0, 64'd0, 0, 0, 1, "R8 code 10");
    send(64'h7FF8_0000_0000_0000, 2'b10, 1'b1, 64'd0, 0, 0, 1, "R8 code 10 NaN bits");
    // R9 back-to-back under stall
    send(64'h0000_0000_4040_0000, 2'b00, 1'b0, 64'd3, 0, 0, 0, "R9 burst single 3.0");
    send(64'h0000_0000_4049_0FDB, 2'b00, 1'b1, 64'd4, 0, 1, 0, "R9 burst single pi");

    begin
      int waited = 0;
      while (sb.size() != 0 && waited < 200) begin
        @(posedge clk);
        waited++;
      end
    end
    @(negedge clk);
    #2;
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9 results missing: actual %0d pending expected 0", sb.size());
    end
    report();
  end
endmodule